// File: doc/BRIEF.md
# Oversampled Slice-Adjust Bit Synchronizer

This block recovers the bit clock and the data from a serial non-return-to-zero stream that is sampled by a slice-rate enable several times per bit. It counts sample slices into bit intervals of nominally seven slices. It decides each bit from a three-slice majority near the middle of the interval. It also watches every pair of neighbouring slices inside the interval for a level change.

When the interval holds a level change, the next interval is made one slice longer or one slice shorter. This moves the interval boundary towards the data edge. After a few adjustments, data edges fall between intervals and no more corrections are needed. A lock flag reports a long run of intervals that needed no correction.

Top module: `bitsync_dpll`

## Requirements
- R1: After reset, and after any interval with no level change inside it, the bit interval lasts exactly SLICES (7) enabled slices.
- R2: The recovered bit is the majority of the three slices at 0-based positions len/2-1, len/2 and len/2+1 of the interval, where len is the current interval length. A single wrong slice among the three therefore does not change the bit.
- R3: Clock cycles with slice_en low advance nothing. The slice count, bit_out and locked all hold.
- R4: A level change counts only between two slices of the same interval (position i differs from position i-1, i >= 1). A change that falls exactly on the boundary between two intervals causes no adjustment.
- R5: If the earliest change inside an interval is at position i with 2*i < len, the next interval lasts SLICES+1 slices.
- R6: If the earliest change is at a position with 2*i >= len, the next interval lasts SLICES-1 slices. Each interval is adjusted by at most one slice, based only on the interval before it.
- R7: bit_vld rises in the cycle after the last slice of an interval and stays high until the next enabled slice, so it covers exactly one slice period. bit_out is updated at that same edge.
- R8: locked rises at the end of the 16th consecutive unadjusted interval. It falls at the end of any adjusted interval.
- R9: While reset is asserted, bit_out, bit_vld and locked are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_en | input | 1 | One-cycle enable for each sample slice |
| ser_in | input | 1 | Serial NRZ input |
| bit_out | output | 1 | Recovered bit |
| bit_vld | output | 1 | Strobe: a new bit is on bit_out |
| locked | output | 1 | Run of unadjusted intervals reached the lock count |

## Verification
The hardest state to reach is a lock that must survive real data transitions. The transmitter's edges have to land exactly on the receiver's interval boundary. The bench first locks on a constant level. It then watches for the strobe and flips the input in the slice that opens the next interval, so the change sits on the boundary rather than inside it. Other runs start the transmitter half a bit out of phase, add periodic one-slice drift, drop enables at random and inject single-slice glitches. These runs drive both the stretch and the shrink paths and the majority vote.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE    = 2'd0,
    ADJ_STRETCH = 2'd1,
    ADJ_SHRINK  = 2'd2
  } adj_e;
endpackage

// File: rtl/bsync_slice_timer.sv
module bsync_slice_timer
  import bsync_pkg::*;
#(
  parameter int SLICES = 7,
  parameter int LW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  adj_e          adj,
  output logic [LW-1:0] cnt,
  output logic [LW-1:0] len,
  output logic          last
);
  localparam logic [LW-1:0] NOM   = LW'(SLICES);
  localparam logic [LW-1:0] LONG  = LW'(SLICES + 1);
  localparam logic [LW-1:0] SHORT = LW'(SLICES - 1);

  logic [LW-1:0] cnt_nx, len_nx;

  assign last = en && (cnt == len - LW'(1));

  always_comb begin
    cnt_nx = cnt;
    len_nx = len;
    if (en) begin
      if (last) begin
        cnt_nx = '0;
        unique case (adj)
          ADJ_STRETCH: len_nx = LONG;
          ADJ_SHRINK:  len_nx = SHORT;
          default:     len_nx = NOM;
        endcase
      end else begin
        cnt_nx = cnt + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      len <= NOM;
    end else begin
      cnt <= cnt_nx;
      len <= len_nx;
    end
  end
endmodule

// File: rtl/bsync_edge_finder.sv
module bsync_edge_finder
  import bsync_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          din,
  input  logic [LW-1:0] cnt,
  input  logic [LW-1:0] len,
  input  logic          last,
  output adj_e          adj
);
  logic          prev_q, found_q;
  logic [LW-1:0] pos_q;
  logic          prev_nx, found_nx;
  logic [LW-1:0] pos_nx;
  logic          cur_chg, any_chg;
  logic [LW-1:0] first_pos;

  assign cur_chg   = en && (cnt != '0) && (din != prev_q);
  assign any_chg   = found_q || cur_chg;
  assign first_pos = found_q ? pos_q : cnt;

  always_comb begin
    if (!any_chg)
      adj = ADJ_NONE;
    else if ({first_pos, 1'b0} < {1'b0, len})
      adj = ADJ_STRETCH;
    else
      adj = ADJ_SHRINK;
  end

  always_comb begin
    prev_nx  = prev_q;
    found_nx = found_q;
    pos_nx   = pos_q;
    if (en) begin
      prev_nx = din;
      if (last) begin
        found_nx = 1'b0;
        pos_nx   = '0;
      end else if (cur_chg && !found_q) begin
        found_nx = 1'b1;
        pos_nx   = cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      found_q <= 1'b0;
      pos_q   <= '0;
    end else begin
      prev_q  <= prev_nx;
      found_q <= found_nx;
      pos_q   <= pos_nx;
    end
  end
endmodule

// File: rtl/bsync_majority.sv
module bsync_majority #(
  parameter int LW     = 4,
  parameter int VOTE_N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          din,
  input  logic [LW-1:0] cnt,
  input  logic [LW-1:0] len,
  input  logic          last,
  output logic          decision
);
  localparam int HALF = VOTE_N / 2;
  localparam int CW   = $clog2(VOTE_N + 1);
  localparam logic [CW-1:0] THRESH = CW'(HALF + 1);

  logic [CW-1:0] ones_q, ones_nx;
  logic [LW-1:0] mid, lo, hi;
  logic          in_win;

  assign mid      = len >> 1;
  assign lo       = mid - LW'(HALF);
  assign hi       = mid + LW'(HALF);
  assign in_win   = (cnt >= lo) && (cnt <= hi);
  assign decision = (ones_q >= THRESH);

  always_comb begin
    ones_nx = ones_q;
    if (en) begin
      if (last)
        ones_nx = '0;
      else if (in_win && din)
        ones_nx = ones_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_nx;
  end
endmodule

// File: rtl/bsync_lock_mon.sv
module bsync_lock_mon
  import bsync_pkg::*;
#(
  parameter int LOCK_N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic last,
  input  adj_e adj,
  output logic locked
);
  localparam int KW = $clog2(LOCK_N + 1);
  localparam logic [KW-1:0] TOP = KW'(LOCK_N);

  logic [KW-1:0] clean_q, clean_nx;

  always_comb begin
    clean_nx = clean_q;
    if (last) begin
      if (adj != ADJ_NONE)   clean_nx = '0;
      else if (clean_q != TOP) clean_nx = clean_q + KW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clean_q <= '0;
    else        clean_q <= clean_nx;
  end

  assign locked = (clean_q == TOP);
endmodule

// File: rtl/bitsync_dpll.sv
module bitsync_dpll
  import bsync_pkg::*;
#(
  parameter int SLICES = 7,
  parameter int VOTE_N = 3,
  parameter int LOCK_N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slice_en,
  input  logic ser_in,
  output logic bit_out,
  output logic bit_vld,
  output logic locked
);
  localparam int LW = $clog2(SLICES + 2);

  logic [LW-1:0] cnt, cur_len;
  logic          last, decision;
  adj_e          adj;
  logic          bit_nx, vld_nx;

  bsync_slice_timer #(.SLICES(SLICES), .LW(LW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(slice_en), .adj(adj),
    .cnt(cnt), .len(cur_len), .last(last)
  );

  bsync_edge_finder #(.LW(LW)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(slice_en), .din(ser_in),
    .cnt(cnt), .len(cur_len), .last(last), .adj(adj)
  );

  bsync_majority #(.LW(LW), .VOTE_N(VOTE_N)) u_vote (
    .clk(clk), .rst_n(rst_n), .en(slice_en), .din(ser_in),
    .cnt(cnt), .len(cur_len), .last(last), .decision(decision)
  );

  bsync_lock_mon #(.LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .last(last), .adj(adj), .locked(locked)
  );

  always_comb begin
    bit_nx = bit_out;
    vld_nx = bit_vld;
    if (slice_en) begin
      vld_nx = last;
      if (last) bit_nx = decision;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out <= 1'b0;
      bit_vld <= 1'b0;
    end else begin
      bit_out <= bit_nx;
      bit_vld <= vld_nx;
    end
  end
endmodule

// File: rtl/bitsync_dpll_chk.sv
module bitsync_dpll_chk #(
  parameter int SLICES = 7,
  parameter int LW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slice_en,
  input logic          bit_out,
  input logic          bit_vld,
  input logic          locked,
  input logic [LW-1:0] cur_len
);
  AST_VLD_ONE_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && slice_en |=> !bit_vld);                                   // R7
  AST_VLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && !slice_en |=> bit_vld);                                   // R7
  AST_BIT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_out) |-> $rose(bit_vld));                               // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slice_en |=> $stable(bit_out) && $stable(locked) && $stable(cur_len)); // R3
  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $rose(bit_vld));                                   // R8
  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $rose(bit_vld));                                   // R8
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_len >= LW'(SLICES - 1)) && (cur_len <= LW'(SLICES + 1)));       // R6
endmodule

bind bitsync_dpll bitsync_dpll_chk #(.SLICES(SLICES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slice_en(slice_en), .bit_out(bit_out),
  .bit_vld(bit_vld), .locked(locked), .cur_len(cur_len)
);

// File: tb/tb_bitsync_dpll.sv
`timescale 1ns/1ps
module tb_bitsync_dpll;
  localparam int SLICES = 7;
  localparam int LOCK_N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic din = 1'b0;
  logic bit_out, bit_vld, locked;

  int vectors = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitsync_dpll #(.SLICES(SLICES), .LOCK_N(LOCK_N)) dut (
    .clk(clk), .rst_n(rst_n), .slice_en(en), .ser_in(din),
    .bit_out(bit_out), .bit_vld(bit_vld), .locked(locked)
  );

  // behavioural reference
  bit q[$];
  int m_len = SLICES, m_clean = 0;
  bit m_bit = 0, m_vld = 0, m_locked = 0;
  bit seen6 = 0, seen8 = 0, seen_lock = 0;
  int gaps = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_len = SLICES; m_clean = 0;
      m_bit = 0; m_vld = 0; m_locked = 0;
    end else if (!en) begin
      gaps++;
    end else begin
      q.push_back(din);
      m_vld = 0;
      if (q.size() == m_len) begin
        automatic int mid = m_len / 2;
        automatic int ones = q[mid-1] + q[mid] + q[mid+1];
        automatic int first = -1;
        m_bit = (ones >= 2);
        m_vld = 1;
        for (int i = 1; i < m_len; i++)
          if (first < 0 && q[i] != q[i-1]) first = i;
        if (first < 0) begin
          m_len = SLICES;
          if (m_clean < LOCK_N) m_clean++;
        end else begin
          m_len = (2 * first < m_len) ? SLICES + 1 : SLICES - 1;
          m_clean = 0;
        end
        if (m_len == SLICES + 1) seen8 = 1;
        if (m_len == SLICES - 1) seen6 = 1;
        m_locked = (m_clean == LOCK_N);
        if (m_locked) seen_lock = 1;
        q.delete();
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(bit_vld == m_vld, "R7 R1 R5 R6 bit_vld", bit_vld, m_vld);
      check(!m_vld || bit_out == m_bit, "R2 bit_out", bit_out, m_bit);
      check(locked == m_locked, "R8 locked", locked, m_locked);
    end
  end

  task automatic hold(bit v, int n);
    for (int s = 0; s < n; ) begin
      @(negedge clk);
      en = 1'b1; din = v; s++;
    end
  endtask

  // mode 0 random, 1 alternate
  task automatic tx_run(int nbits, int mode, int drift_every, int en_pct, int glitch_pct);
    for (int b = 0; b < nbits; b++) begin
      automatic bit v = (mode == 1) ? bit'(b % 2) : bit'($urandom_range(0, 1));
      automatic int blen = SLICES + ((drift_every > 0 && b % drift_every == drift_every - 1) ? 1 : 0);
      for (int s = 0; s < blen; ) begin
        @(negedge clk);
        en = ($urandom_range(0, 99) < en_pct);
        din = v;
        if (en && s == blen / 2 && $urandom_range(0, 99) < glitch_pct) din = ~v;
        if (en) s++;
      end
    end
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog actual=0 expected=1");
    fails++;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bit_out == 0, "R9 bit_out", bit_out, 0);
    check(bit_vld == 0, "R9 bit_vld", bit_vld, 0);
    check(locked == 0, "R9 locked", locked, 0);
    rst_n = 1'b1;

    // R1 constant level: fixed intervals, lock
    hold(1'b0, SLICES * 20);
    check(locked == 1, "R8 lock after clean run", locked, 1);

    // R4 flip exactly on a boundary: no adjustment, lock kept
    @(negedge clk); en = 1'b1;
    while (!bit_vld) @(negedge clk);
    din = 1'b1;
    hold(1'b1, SLICES * 20);
    check(locked == 1, "R4 boundary change keeps lock", locked, 1);

    // R5 R6 half-bit offset then random data
    hold(1'b0, 3);
    tx_run(200, 0, 0, 100, 0);
    tx_run(200, 1, 0, 100, 0);
    // drift, enable gaps (R3), glitches (R2)
    tx_run(300, 0, 6, 60, 0);
    tx_run(300, 0, 0, 100, 30);
    tx_run(200, 1, 9, 50, 20);
    @(negedge clk); en = 1'b0;
    repeat (20) @(negedge clk);

    check(seen8, "R5 stretch seen", seen8, 1);
    check(seen6, "R6 shrink seen", seen6, 1);
    check(seen_lock, "R8 lock seen", seen_lock, 1);
    check(gaps > 100, "R3 idle cycles applied", gaps, 101);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule